// File: doc/BRIEF.md
# Write-Permit and Protection Status Controller

This block holds the status byte of a serial non-volatile memory. It also decides whether a requested status write or page write may go ahead, and it runs the self-timed write cycle. A command engine sits in front of it. That engine hands over one-cycle strobes once a command frame has been fully received: set-permit, clear-permit, status write with its data byte, and page write with the page's byte address. It raises `frame_end_i` when chip select returns high. It raises `abort_i` when the frame ended at an illegal bit count.

A status write or page write is only staged when its strobe arrives. It is acted on when the frame closes. An accepted request starts a busy window of `WCYC` system clocks. A page write also sends a one-cycle commit strobe with its page address to the array. A status write loads its new protection bits when the busy window ends. The permit latch is cleared at that same moment.

Top module: `wpc_top`

## Requirements
- R1: After reset, `status_o` reads 0x00, `busy_o` is 0 and `arr_wr_o` is 0.
- R2: The permit latch (status bit 1) is set only when a set-permit strobe is followed by `frame_end_i`. Another command strobe or `abort_i` arriving in between cancels the set.
- R3: A clear-permit strobe clears the permit latch one cycle later, even during a busy window. The latch is also cleared when the busy window of an accepted status or page write ends.
- R4: The status byte is: bit 7 lock-enable, bits 6..4 always 0, bits 3..2 protect level, bit 1 permit latch, bit 0 busy. Bits 6..4 and 1..0 of written data are discarded.
- R5: A status write is accepted only if the permit latch is 1 and not (lock-enable is 1 and `wp_n_i` is 0). When lock-enable is 0, `wp_n_i` has no effect. A refused status write changes no status bit.
- R6: An accepted request raises `busy_o` in the cycle after the closing `frame_end_i` and holds it for exactly `WCYC` cycles.
- R7: An accepted page write pulses `arr_wr_o` for one cycle, in the first busy cycle, with `arr_page_o` equal to the requested address.
- R8: Protect level 00 protects nothing, 01 protects addresses whose top two bits are 11, 10 protects addresses whose top bit is 1, and 11 protects all. A write to a protected page gives no pulse and no busy window, and leaves the permit latch unchanged.
- R9: Set-permit, status-write and page-write strobes arriving while busy are ignored.
- R10: A `wp_n_i` change after a status write was accepted does not alter the bits it loads.
- R11: With the permit latch at 0, status writes and page writes are dropped without a busy window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wren_i | input | 1 | Set-permit frame received |
| wrdi_i | input | 1 | Clear-permit frame received |
| wrsr_i | input | 1 | Status-write frame received |
| wrsr_data_i | input | 8 | Data byte of status write |
| wrpg_i | input | 1 | Page-write frame received |
| wrpg_addr_i | input | ADDR_W | Byte address of the page |
| frame_end_i | input | 1 | Chip select returned high |
| abort_i | input | 1 | Frame terminated illegally |
| wp_n_i | input | 1 | Write-protect pin, active low |
| status_o | output | 8 | Status byte |
| busy_o | output | 1 | Self-timed cycle running |
| arr_wr_o | output | 1 | Array commit strobe |
| arr_page_o | output | ADDR_W | Address for array commit |

## Verification
The assertions check several rules on every cycle. The permit latch rises only straight after a frame end, and it never rises while busy. It is low once a busy window ends. A commit strobe only comes at the first busy cycle, and a running window does not stop early. Other behaviour can only be shown by the bench's scenarios: the exact window length, the protect-level address mapping, refusal under the write-protect pin, and discarded data bits. The same holds for cancelled set-permit frames and pin changes made during a cycle.

// File: rtl/wpc_pkg.sv
package wpc_pkg;
  typedef enum logic [1:0] {
    STG_NONE = 2'd0,
    STG_WREN = 2'd1,
    STG_WRSR = 2'd2,
    STG_WRPG = 2'd3
  } stage_t;

  // protect level vs. top two address bits
  function automatic logic prot_hit(input logic [1:0] lvl, input logic [1:0] top2);
    case (lvl)
      2'b00:   prot_hit = 1'b0;
      2'b01:   prot_hit = (top2 == 2'b11);
      2'b10:   prot_hit = top2[1];
      default: prot_hit = 1'b1;
    endcase
  endfunction
endpackage

// File: rtl/wpc_stage.sv
module wpc_stage
  import wpc_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy,
  input  logic              wren,
  input  logic              wrdi,
  input  logic              wrsr,
  input  logic [2:0]        wrsr_bits,
  input  logic              wrpg,
  input  logic [ADDR_W-1:0] wrpg_addr,
  input  logic              frame_end,
  input  logic              abort,
  output stage_t            op,
  output logic [2:0]        bits,
  output logic [ADDR_W-1:0] page
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op   <= STG_NONE;
      bits <= '0;
      page <= '0;
    end else if (abort || frame_end || wrdi) begin
      op <= STG_NONE;
    end else if (!busy) begin
      if (wren) begin
        op <= STG_WREN;
      end else if (wrsr) begin
        op   <= STG_WRSR;
        bits <= wrsr_bits;
      end else if (wrpg) begin
        op   <= STG_WRPG;
        page <= wrpg_addr;
      end
    end
  end
endmodule

// File: rtl/wpc_timer.sv
module wpc_timer #(
  parameter int WCYC  = 1000000,
  localparam int CNT_W = $clog2(WCYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic running,
  output logic done
);
  logic [CNT_W-1:0] remain;

  assign done = running && (remain == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running <= 1'b0;
      remain  <= '0;
    end else if (start) begin
      running <= 1'b1;
      remain  <= CNT_W'(WCYC - 1);
    end else if (running) begin
      if (remain == '0) running <= 1'b0;
      else              remain  <= remain - 1'b1;
    end
  end

  // R6
  hold_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    running && (remain != '0) |=> running);
  // R9
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !running);
endmodule

// File: rtl/wpc_top.sv
module wpc_top
  import wpc_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int WCYC   = 1000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wren_i,
  input  logic              wrdi_i,
  input  logic              wrsr_i,
  input  logic [7:0]        wrsr_data_i,
  input  logic              wrpg_i,
  input  logic [ADDR_W-1:0] wrpg_addr_i,
  input  logic              frame_end_i,
  input  logic              abort_i,
  input  logic              wp_n_i,
  output logic [7:0]        status_o,
  output logic              busy_o,
  output logic              arr_wr_o,
  output logic [ADDR_W-1:0] arr_page_o
);
  stage_t            st_op;
  logic [2:0]        st_bits;
  logic [ADDR_W-1:0] st_page;
  logic              cyc_run, cyc_done;

  logic              wel_q, lock_q, is_sr_q;
  logic [1:0]        lvl_q;
  logic [2:0]        pend_q;

  // named internal events
  logic commit_ev, sr_locked, pg_prot, sr_ok, pg_ok, wel_set, cyc_start;

  wpc_stage #(.ADDR_W(ADDR_W)) u_stage (
    .clk(clk), .rst_n(rst_n), .busy(cyc_run),
    .wren(wren_i), .wrdi(wrdi_i),
    .wrsr(wrsr_i), .wrsr_bits({wrsr_data_i[7], wrsr_data_i[3:2]}),
    .wrpg(wrpg_i), .wrpg_addr(wrpg_addr_i),
    .frame_end(frame_end_i), .abort(abort_i),
    .op(st_op), .bits(st_bits), .page(st_page)
  );

  wpc_timer #(.WCYC(WCYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(cyc_start),
    .running(cyc_run), .done(cyc_done)
  );

  assign commit_ev = frame_end_i && !cyc_run;
  assign sr_locked = lock_q && !wp_n_i;
  assign pg_prot   = prot_hit(lvl_q, st_page[ADDR_W-1 -: 2]);
  assign sr_ok     = commit_ev && (st_op == STG_WRSR) && wel_q && !sr_locked;
  assign pg_ok     = commit_ev && (st_op == STG_WRPG) && wel_q && !pg_prot;
  assign wel_set   = commit_ev && (st_op == STG_WREN);
  assign cyc_start = sr_ok || pg_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wel_q      <= 1'b0;
      lock_q     <= 1'b0;
      lvl_q      <= 2'b00;
      is_sr_q    <= 1'b0;
      pend_q     <= '0;
      arr_wr_o   <= 1'b0;
      arr_page_o <= '0;
    end else begin
      arr_wr_o <= pg_ok;
      if (pg_ok) arr_page_o <= st_page;
      if (cyc_start) begin
        is_sr_q <= sr_ok;
        pend_q  <= st_bits;
      end
      if (cyc_done && is_sr_q) begin
        lock_q <= pend_q[2];
        lvl_q  <= pend_q[1:0];
      end
      if (wrdi_i || cyc_done) wel_q <= 1'b0;
      else if (wel_set)       wel_q <= 1'b1;
    end
  end

  assign busy_o   = cyc_run;
  assign status_o = {lock_q, 3'b000, lvl_q, wel_q, cyc_run};

  // R2
  wel_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wel_q) |-> $past(frame_end_i));
  // R9
  wel_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_run |=> !$rose(wel_q));
  // R3
  wel_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> !wel_q);
  // R7
  commit_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arr_wr_o |-> $rose(busy_o));
endmodule

// File: tb/tb_wpc_top.sv
module tb_wpc_top;
  localparam int AW = 10;
  localparam int WC = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wren = 0, wrdi = 0, wrsr = 0, wrpg = 0, fend = 0, abrt = 0, wp_n = 1;
  logic [7:0] sdat = '0;
  logic [AW-1:0] padr = '0;
  logic [7:0] status;
  logic busy, awr;
  logic [AW-1:0] apage;

  int checks = 0, errors = 0, cyc = 0;
  logic got_pulse;
  logic [AW-1:0] got_page;
  logic got_busy;

  always #2.5 clk = ~clk;

  wpc_top #(.ADDR_W(AW), .WCYC(WC)) dut (
    .clk(clk), .rst_n(rst_n), .wren_i(wren), .wrdi_i(wrdi), .wrsr_i(wrsr),
    .wrsr_data_i(sdat), .wrpg_i(wrpg), .wrpg_addr_i(padr), .frame_end_i(fend),
    .abort_i(abrt), .wp_n_i(wp_n), .status_o(status), .busy_o(busy),
    .arr_wr_o(awr), .arr_page_o(apage)
  );

  // op: 0 none, 1 set-permit, 2 clear-permit, 3 status write, 4 page write
  function automatic logic [31:0] mkv(input int op, input logic [7:0] d, input logic [9:0] a,
                                      input logic w, input logic [7:0] st, input logic p, input logic b);
    return {op[2:0], d, a, w, st, p, b};
  endfunction

  localparam int NV = 23;
  localparam logic [31:0] VEC [NV] = '{
    mkv(3, 8'h8C, 10'h000, 1, 8'h00, 0, 0),  // R11 no permit
    mkv(4, 8'h00, 10'h000, 1, 8'h00, 0, 0),  // R11
    mkv(1, 8'h00, 10'h000, 1, 8'h02, 0, 0),  // R2
    mkv(2, 8'h00, 10'h000, 1, 8'h00, 0, 0),  // R3
    mkv(1, 8'h00, 10'h000, 1, 8'h02, 0, 0),
    mkv(3, 8'h84, 10'h000, 1, 8'h84, 0, 1),  // R5 lock=1 lvl=01
    mkv(1, 8'h00, 10'h000, 1, 8'h86, 0, 0),
    mkv(4, 8'h00, 10'h300, 1, 8'h86, 0, 0),  // R8 lvl 01 protected
    mkv(4, 8'h00, 10'h2F0, 1, 8'h84, 1, 1),  // R7
    mkv(1, 8'h00, 10'h000, 1, 8'h86, 0, 0),
    mkv(3, 8'h00, 10'h000, 0, 8'h86, 0, 0),  // R5 locked by pin
    mkv(3, 8'h88, 10'h000, 1, 8'h88, 0, 1),  // R5 lvl 10
    mkv(1, 8'h00, 10'h000, 1, 8'h8A, 0, 0),
    mkv(4, 8'h00, 10'h200, 1, 8'h8A, 0, 0),  // R8 lvl 10
    mkv(4, 8'h00, 10'h1F0, 1, 8'h88, 1, 1),  // R8
    mkv(1, 8'h00, 10'h000, 1, 8'h8A, 0, 0),
    mkv(3, 8'h7F, 10'h000, 1, 8'h0C, 0, 1),  // R4 discarded bits
    mkv(1, 8'h00, 10'h000, 1, 8'h0E, 0, 0),
    mkv(4, 8'h00, 10'h000, 1, 8'h0E, 0, 0),  // R8 lvl 11
    mkv(3, 8'h00, 10'h000, 0, 8'h00, 0, 1),  // R5 pin ignored
    mkv(1, 8'h00, 10'h000, 1, 8'h02, 0, 0),
    mkv(4, 8'h00, 10'h3F0, 1, 8'h00, 1, 1),  // R8 lvl 00
    mkv(0, 8'h00, 10'h000, 1, 8'h00, 0, 0)   // R6 frame end alone
  };

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send(input int op, input logic [7:0] d, input logic [AW-1:0] a);
    @(negedge clk);
    case (op)
      1: wren = 1;
      2: wrdi = 1;
      3: begin wrsr = 1; sdat = d; end
      4: begin wrpg = 1; padr = a; end
      default: ;
    endcase
    @(negedge clk);
    wren = 0; wrdi = 0; wrsr = 0; wrpg = 0; fend = 1;
    @(negedge clk);
    fend = 0;
    got_pulse = awr; got_page = apage; got_busy = busy;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy && n < WC + 10) begin n++; @(negedge clk); end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk(status == 8'h00, "R1 status", status, 0);
    chk(!busy && !awr, "R1 busy/strobe", {busy, awr}, 0);

    for (int i = 0; i < NV; i++) begin
      logic [31:0] v;
      v = VEC[i];
      wp_n = v[10];
      send(int'(v[31:29]), v[28:21], v[20:11]);
      chk(got_pulse == v[1], "R7/R8 commit strobe", got_pulse, v[1]);
      if (v[1]) chk(got_page == v[20:11], "R7 page", got_page, v[20:11]);
      chk(got_busy == v[0], "R6 busy start", got_busy, v[0]);
      if (v[0]) chk(status[0] == 1'b1, "R4 busy bit", status[0], 1);
      wait_idle(n);
      chk(n == (v[0] ? WC : 0), "R6 window length", n, v[0] ? WC : 0);
      chk(status == v[9:2], "R5/R8 status", status, v[9:2]);
    end

    // R2: another strobe between set-permit and frame end
    wp_n = 1;
    @(negedge clk); wren = 1;
    @(negedge clk); wren = 0; wrpg = 1; padr = '0;
    @(negedge clk); wrpg = 0; fend = 1;
    @(negedge clk); fend = 0;
    chk(status[1] == 1'b0, "R2 cancelled by strobe", status[1], 0);
    chk(!awr && !busy, "R2 no commit", {awr, busy}, 0);
    // R2: abort between set-permit and frame end
    @(negedge clk); wren = 1;
    @(negedge clk); wren = 0; abrt = 1;
    @(negedge clk); abrt = 0; fend = 1;
    @(negedge clk); fend = 0;
    chk(status[1] == 1'b0, "R2 cancelled by abort", status[1], 0);

    // R3 / R9 during busy
    send(1, 0, 0);
    send(4, 0, 10'h040);
    chk(got_pulse == 1'b1, "R7 commit", got_pulse, 1);
    send(2, 0, 0);
    chk(status[1] == 1'b0 && busy, "R3 clear while busy", status, 8'h01);
    send(1, 0, 0);
    chk(status[1] == 1'b0, "R9 set-permit ignored", status[1], 0);
    send(4, 0, 10'h080);
    chk(got_pulse == 1'b0, "R9 page write ignored", got_pulse, 0);
    wait_idle(n);
    chk(status == 8'h00, "R9 status after", status, 0);

    // R10: pin falls during an accepted status write
    send(1, 0, 0);
    send(3, 8'h84, 0);
    wp_n = 0;
    wait_idle(n);
    chk(status == 8'h84, "R10 pin change mid-cycle", status, 8'h84);
    send(1, 0, 0);
    send(3, 8'h00, 0);
    chk(!got_busy, "R5 locked refuse", got_busy, 0);
    chk(status == 8'h86, "R5 locked status", status, 8'h86);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule